// File: doc/BRIEF.md
# Indexed and Auto-Increment Address Generator

This unit computes memory addresses for a family of custom load and store operations on a 64-bit core. For each accepted request it produces one or two effective addresses. For operations that update their base register it also produces the new base value and a write-back enable. Encodings whose register numbers overlap in a way the operation cannot honour raise an illegal flag.

Three operation classes are supported. The indexed class adds a scaled index register to a base, and the index may first be cut to its low 32 bits. The stepping class moves the base by a scaled immediate and accesses the old base or the new one. The paired class issues two accesses at consecutive addresses. The decode stage drives one request per strobe, and the results appear registered on the next clock with a matching valid. Memory access, alignment and data extension are handled elsewhere.

Top module: `xaddr_gen`

## Requirements
- R1: Class 0 (indexed): addr0 = base + (index << scale), where scale is 0 to 3. The address is valid, and the second address and base write-back stay off.
- R2: In class 0 with idx_zext = 1, bits 63:32 of index are treated as zero before the shift and add.
- R3: Class 1 (stepping): step = sign-extended step_imm (5-bit two's complement) << scale. wb_data = base + step and wb_en = 1 for both loads and stores.
- R4: In class 1, pre_inc = 0 gives addr0 = base (old value), and pre_inc = 1 gives addr0 = base + step.
- R5: A class 1 load (is_load = 1) with rs_base == rd_a is illegal. A class 1 store has no register-overlap check.
- R6: Class 2 (paired): the offset is pair_imm << 4 when pair_dw = 1 (8-byte elements) and pair_imm << 3 when pair_dw = 0 (4-byte elements). addr0 = base + offset, and addr1 = addr0 + 8 or + 4 with addr1_en = 1.
- R7: A class 2 load is illegal when rs_base equals rd_a or rd_b, or when rd_a equals rd_b. A class 2 store has no overlap check.
- R8: Class 3 is reserved and always illegal. Whenever illegal = 1, addr_ok, addr1_en and wb_en are all 0.
- R9: Results are registered. out_valid is in_valid delayed by one clock. Under synchronous active-low reset, out_valid and all outputs are 0.
- R10: All address and write-back arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_cls | input | 2 | 0 indexed, 1 stepping, 2 paired, 3 reserved |
| is_load | input | 1 | 1 for a load, 0 for a store |
| idx_zext | input | 1 | Use only the low 32 index bits (indexed class) |
| pre_inc | input | 1 | Access the updated base (stepping class) |
| pair_dw | input | 1 | 8-byte pair elements when 1, 4-byte when 0 |
| scale | input | 2 | Left shift applied to the index or the step immediate |
| step_imm | input | 5 | Signed step immediate |
| pair_imm | input | 2 | Pair offset immediate |
| rs_base | input | 5 | Base register number |
| rd_a | input | 5 | First destination or data register number |
| rd_b | input | 5 | Second destination register number (paired class) |
| base | input | 64 | Base register value |
| index | input | 64 | Index register value |
| out_valid | output | 1 | Result valid |
| addr0 | output | 64 | First effective address |
| addr1 | output | 64 | Second effective address (paired class) |
| addr_ok | output | 1 | addr0 may be used |
| addr1_en | output | 1 | addr1 may be used |
| wb_en | output | 1 | Write wb_data back to the base register |
| wb_data | output | 64 | Updated base value |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The hardest cases to reach are the ones where a register-overlap test and the arithmetic carry both matter: a stepping store whose base and data register numbers match, and a paired store whose three register numbers are all equal. Both must stay legal, and both must still give correct addresses. The vector table includes these cases next to the matching illegal loads. Other vectors push the base near 2^64 so that the step, pair offset and second address all wrap. A last set of vectors uses an index with ones in its upper half, so the zero-extension variant gives a result that differs from the full-width add.

// File: rtl/xaddr_pkg.sv
// Package: shared encodings for the address generator.
// Assumes: the operation class is decoded upstream into a 2-bit code.
package xaddr_pkg;

    typedef enum logic [1:0] {
        OPC_INDEX = 2'd0,
        OPC_STEP  = 2'd1,
        OPC_PAIR  = 2'd2,
        OPC_RSVD  = 2'd3
    } opc_e;

    // log2 of the element size in bytes for the two pair widths
    localparam int PAIR_DW_LOG2 = 3;
    localparam int PAIR_W_LOG2  = 2;
    // the offset shift is one more than the element size log2 (two elements per pair)
    localparam int PAIR_DW_SH   = PAIR_DW_LOG2 + 1;
    localparam int PAIR_W_SH    = PAIR_W_LOG2 + 1;

endpackage

// File: rtl/xaddr_index_path.sv
// Module: xaddr_index_path
// Computes base + (index << scale). When zext is set, only the low LOW_W
// bits of index are used. Purely combinational.
// Assumes: AW > LOW_W.
module xaddr_index_path #(
    parameter int AW    = 64,
    parameter int LOW_W = 32,
    parameter int SHW   = 2
) (
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  index,
    input  logic           zext,
    input  logic [SHW-1:0] scale,
    output logic [AW-1:0]  addr
);
    localparam int HI_W = AW - LOW_W;

    logic [AW-1:0] idx_eff;

    // select full index or its zero-extended low part, then scale and add
    always_comb begin
        idx_eff = zext ? {{HI_W{1'b0}}, index[LOW_W-1:0]} : index;
        addr    = base + (idx_eff << scale);
    end
endmodule

// File: rtl/xaddr_step_path.sv
// Module: xaddr_step_path
// Computes the stepped base (base + sext(imm) << scale) and the access
// address, which is the new or old base depending on pre.
// Assumes: imm is a two's complement value of IMMW bits.
module xaddr_step_path #(
    parameter int AW   = 64,
    parameter int IMMW = 5,
    parameter int SHW  = 2
) (
    input  logic [AW-1:0]   base,
    input  logic [IMMW-1:0] imm,
    input  logic [SHW-1:0]  scale,
    input  logic            pre,
    output logic [AW-1:0]   addr,
    output logic [AW-1:0]   next_base
);
    localparam int EXT_W = AW - IMMW;

    logic [AW-1:0] step;

    // sign-extend and scale the step, form the new base and pick the access address
    always_comb begin
        step      = {{EXT_W{imm[IMMW-1]}}, imm} << scale;
        next_base = base + step;
        addr      = pre ? next_base : base;
    end
endmodule

// File: rtl/xaddr_pair_path.sv
// Module: xaddr_pair_path
// Computes the two consecutive addresses of a paired access. The offset
// immediate is scaled by twice the element size. The second address is
// one element above the first.
// Assumes: only 4-byte and 8-byte elements exist.
module xaddr_pair_path
    import xaddr_pkg::*;
#(
    parameter int AW    = 64,
    parameter int PIMMW = 2
) (
    input  logic [AW-1:0]    base,
    input  logic [PIMMW-1:0] pimm,
    input  logic             dw,
    output logic [AW-1:0]    addr0,
    output logic [AW-1:0]    addr1
);
    localparam int PAD_W = AW - PIMMW;

    logic [AW-1:0] pimm_ext;
    logic [AW-1:0] offset;
    logic [AW-1:0] gap;

    // scale the offset by the pair width and add the element gap
    always_comb begin
        pimm_ext = {{PAD_W{1'b0}}, pimm};
        offset   = dw ? (pimm_ext << PAIR_DW_SH) : (pimm_ext << PAIR_W_SH);
        gap      = dw ? (AW'(1) << PAIR_DW_LOG2) : (AW'(1) << PAIR_W_LOG2);
        addr0    = base + offset;
        addr1    = addr0 + gap;
    end
endmodule

// File: rtl/xaddr_overlap.sv
// Module: xaddr_overlap
// Flags encodings that are illegal because of register-number overlap,
// and flags the reserved class. Stores are never rejected for overlap.
// Assumes: register numbers are RW bits wide.
module xaddr_overlap
    import xaddr_pkg::*;
#(
    parameter int RW = 5
) (
    input  opc_e          opc,
    input  logic          is_load,
    input  logic [RW-1:0] rs,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    output logic          bad
);
    // decide legality per class
    always_comb begin
        case (opc)
            OPC_STEP: bad = is_load && (rs == ra);
            OPC_PAIR: bad = is_load && ((rs == ra) || (rs == rb) || (ra == rb));
            OPC_RSVD: bad = 1'b1;
            default:  bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/xaddr_gen.sv
// Module: xaddr_gen (top)
// Address generator for indexed, stepping and paired custom loads/stores.
// All three paths are computed in parallel, one is selected by class,
// legality gates the enables, and the result is registered on in_valid.
// Assumes: one request per strobe; outputs hold between strobes.
module xaddr_gen
    import xaddr_pkg::*;
#(
    parameter int AW    = 64,
    parameter int RW    = 5,
    parameter int SHW   = 2,
    parameter int IMMW  = 5,
    parameter int PIMMW = 2,
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_cls,
    input  logic             is_load,
    input  logic             idx_zext,
    input  logic             pre_inc,
    input  logic             pair_dw,
    input  logic [SHW-1:0]   scale,
    input  logic [IMMW-1:0]  step_imm,
    input  logic [PIMMW-1:0] pair_imm,
    input  logic [RW-1:0]    rs_base,
    input  logic [RW-1:0]    rd_a,
    input  logic [RW-1:0]    rd_b,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    index,
    output logic             out_valid,
    output logic [AW-1:0]    addr0,
    output logic [AW-1:0]    addr1,
    output logic             addr_ok,
    output logic             addr1_en,
    output logic             wb_en,
    output logic [AW-1:0]    wb_data,
    output logic             illegal
);
    opc_e          opc;
    logic [AW-1:0] idx_addr;
    logic [AW-1:0] stp_addr;
    logic [AW-1:0] stp_next;
    logic [AW-1:0] par_a0;
    logic [AW-1:0] par_a1;
    logic          bad;

    logic [AW-1:0] n_a0;
    logic [AW-1:0] n_a1;
    logic [AW-1:0] n_wbd;
    logic          n_ok;
    logic          n_a1en;
    logic          n_wb;

    assign opc = opc_e'(op_cls);

    xaddr_index_path #(.AW(AW), .LOW_W(LOW_W), .SHW(SHW)) u_idx (
        .base  (base),
        .index (index),
        .zext  (idx_zext),
        .scale (scale),
        .addr  (idx_addr)
    );

    xaddr_step_path #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_stp (
        .base      (base),
        .imm       (step_imm),
        .scale     (scale),
        .pre       (pre_inc),
        .addr      (stp_addr),
        .next_base (stp_next)
    );

    xaddr_pair_path #(.AW(AW), .PIMMW(PIMMW)) u_par (
        .base  (base),
        .pimm  (pair_imm),
        .dw    (pair_dw),
        .addr0 (par_a0),
        .addr1 (par_a1)
    );

    xaddr_overlap #(.RW(RW)) u_ovl (
        .opc     (opc),
        .is_load (is_load),
        .rs      (rs_base),
        .ra      (rd_a),
        .rb      (rd_b),
        .bad     (bad)
    );

    // choose the class result and gate the enables with legality
    always_comb begin
        n_a0  = idx_addr;
        n_a1  = '0;
        n_wbd = '0;
        case (opc)
            OPC_STEP: begin
                n_a0  = stp_addr;
                n_wbd = stp_next;
            end
            OPC_PAIR: begin
                n_a0 = par_a0;
                n_a1 = par_a1;
            end
            default: ;
        endcase
        n_ok   = !bad;
        n_a1en = (opc == OPC_PAIR) && !bad;
        n_wb   = (opc == OPC_STEP) && !bad;
    end

    // output register: capture on strobe, valid follows the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            addr0     <= '0;
            addr1     <= '0;
            addr_ok   <= 1'b0;
            addr1_en  <= 1'b0;
            wb_en     <= 1'b0;
            wb_data   <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                addr0    <= n_a0;
                addr1    <= n_a1;
                addr_ok  <= n_ok;
                addr1_en <= n_a1en;
                wb_en    <= n_wb;
                wb_data  <= n_wbd;
                illegal  <= bad;
            end
        end
    end
endmodule

// File: rtl/xaddr_gen_chk.sv
// Module: xaddr_gen_chk
// Temporal checks on the address generator ports, bound to the top.
module xaddr_gen_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    op_cls,
    input logic          pre_inc,
    input logic          pair_dw,
    input logic [AW-1:0] base,
    input logic          out_valid,
    input logic [AW-1:0] addr0,
    input logic [AW-1:0] addr1,
    input logic          addr_ok,
    input logic          addr1_en,
    input logic          wb_en,
    input logic [AW-1:0] wb_data,
    input logic          illegal
);
    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (!addr_ok && !addr1_en && !wb_en));

    // R6
    pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && addr1_en) |->
            ((addr1 - addr0) == ($past(pair_dw) ? AW'(8) : AW'(4))));

    // R4
    pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en && $past(pre_inc)) |-> (addr0 == wb_data));

    // R4
    post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en && !$past(pre_inc)) |-> (addr0 == $past(base)));

    // R1
    idx_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_cls) == 2'd0)) |-> (!wb_en && !addr1_en));
endmodule

bind xaddr_gen xaddr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_cls    (op_cls),
    .pre_inc   (pre_inc),
    .pair_dw   (pair_dw),
    .base      (base),
    .out_valid (out_valid),
    .addr0     (addr0),
    .addr1     (addr1),
    .addr_ok   (addr_ok),
    .addr1_en  (addr1_en),
    .wb_en     (wb_en),
    .wb_data   (wb_data),
    .illegal   (illegal)
);

// File: tb/sim_xaddr_gen.sv
`timescale 1ns/1ps
module sim_xaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_cls = 2'd0;
    logic        is_load = 1'b0;
    logic        idx_zext = 1'b0;
    logic        pre_inc = 1'b0;
    logic        pair_dw = 1'b0;
    logic [1:0]  scale = 2'd0;
    logic [4:0]  step_imm = 5'd0;
    logic [1:0]  pair_imm = 2'd0;
    logic [4:0]  rs_base = 5'd0;
    logic [4:0]  rd_a = 5'd0;
    logic [4:0]  rd_b = 5'd0;
    logic [63:0] base = 64'd0;
    logic [63:0] index = 64'd0;
    logic        out_valid;
    logic [63:0] addr0;
    logic [63:0] addr1;
    logic        addr_ok;
    logic        addr1_en;
    logic        wb_en;
    logic [63:0] wb_data;
    logic        illegal;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xaddr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_cls(op_cls),
        .is_load(is_load), .idx_zext(idx_zext), .pre_inc(pre_inc),
        .pair_dw(pair_dw), .scale(scale), .step_imm(step_imm),
        .pair_imm(pair_imm), .rs_base(rs_base), .rd_a(rd_a), .rd_b(rd_b),
        .base(base), .index(index), .out_valid(out_valid), .addr0(addr0),
        .addr1(addr1), .addr_ok(addr_ok), .addr1_en(addr1_en),
        .wb_en(wb_en), .wb_data(wb_data), .illegal(illegal)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        ld;
        logic        zx;
        logic        pre;
        logic        dw;
        logic [1:0]  sc;
        logic [4:0]  imm;
        logic [1:0]  pimm;
        logic [4:0]  rs;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [63:0] b;
        logic [63:0] ix;
        logic [63:0] e_a0;
        logic [63:0] e_a1;
        logic        e_ok;
        logic        e_a1en;
        logic        e_wb;
        logic [63:0] e_wbd;
        logic        e_ill;
    } vec_t;

    localparam int NV = 15;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] Z = 64'd0;

    localparam vec_t VECS [NV] = '{
        // R1 plain indexed, scale 2
        '{2'd0,1'b0,1'b0,1'b0,1'b0,2'd2,5'd0,2'd0,5'd1,5'd2,5'd3,64'h1000,64'h10,64'h1040,Z,1'b1,1'b0,1'b0,Z,1'b0},
        // R1 R10 negative index wraps
        '{2'd0,1'b1,1'b0,1'b0,1'b0,2'd3,5'd0,2'd0,5'd1,5'd2,5'd3,64'h100,ONES,64'hF8,Z,1'b1,1'b0,1'b0,Z,1'b0},
        // R2 zero-extended index
        '{2'd0,1'b1,1'b1,1'b0,1'b0,2'd0,5'd0,2'd0,5'd1,5'd2,5'd3,64'h100,ONES,64'h1_0000_00FF,Z,1'b1,1'b0,1'b0,Z,1'b0},
        // R2 high index bits dropped
        '{2'd0,1'b0,1'b1,1'b0,1'b0,2'd1,5'd0,2'd0,5'd1,5'd2,5'd3,Z,64'hABCD_0000_0000_0010,64'h20,Z,1'b1,1'b0,1'b0,Z,1'b0},
        // R3 R4 post-step load
        '{2'd1,1'b1,1'b0,1'b0,1'b0,2'd2,5'd3,2'd0,5'd1,5'd2,5'd3,64'h2000,Z,64'h2000,Z,1'b1,1'b0,1'b1,64'h200C,1'b0},
        // R3 R4 R5 pre-step store, negative step, base == data register
        '{2'd1,1'b0,1'b0,1'b1,1'b0,2'd3,5'h1E,2'd0,5'd5,5'd5,5'd3,64'h2000,Z,64'h1FF0,Z,1'b1,1'b0,1'b1,64'h1FF0,1'b0},
        // R5 step load with base == destination
        '{2'd1,1'b1,1'b0,1'b0,1'b0,2'd0,5'd1,2'd0,5'd7,5'd7,5'd3,64'h2000,Z,Z,Z,1'b0,1'b0,1'b0,Z,1'b1},
        // R10 pre-step wraps past 2^64
        '{2'd1,1'b1,1'b0,1'b1,1'b0,2'd3,5'd2,2'd0,5'd1,5'd2,5'd3,64'hFFFF_FFFF_FFFF_FFF8,Z,64'h8,Z,1'b1,1'b0,1'b1,64'h8,1'b0},
        // R6 doubleword pair
        '{2'd2,1'b1,1'b0,1'b0,1'b1,2'd0,5'd0,2'd3,5'd1,5'd2,5'd3,64'h3000,Z,64'h3030,64'h3038,1'b1,1'b1,1'b0,Z,1'b0},
        // R6 word pair
        '{2'd2,1'b1,1'b0,1'b0,1'b0,2'd0,5'd0,2'd2,5'd1,5'd2,5'd3,64'h3000,Z,64'h3010,64'h3014,1'b1,1'b1,1'b0,Z,1'b0},
        // R7 pair load, equal destinations
        '{2'd2,1'b1,1'b0,1'b0,1'b1,2'd0,5'd0,2'd0,5'd1,5'd4,5'd4,64'h3000,Z,Z,Z,1'b0,1'b0,1'b0,Z,1'b1},
        // R7 pair load, base == second destination
        '{2'd2,1'b1,1'b0,1'b0,1'b0,2'd0,5'd0,2'd1,5'd6,5'd2,5'd6,64'h3000,Z,Z,Z,1'b0,1'b0,1'b0,Z,1'b1},
        // R7 pair store with all registers equal stays legal
        '{2'd2,1'b0,1'b0,1'b0,1'b1,2'd0,5'd0,2'd0,5'd9,5'd9,5'd9,64'h40,Z,64'h40,64'h48,1'b1,1'b1,1'b0,Z,1'b0},
        // R8 reserved class
        '{2'd3,1'b0,1'b0,1'b0,1'b0,2'd0,5'd0,2'd0,5'd1,5'd2,5'd3,64'h40,Z,Z,Z,1'b0,1'b0,1'b0,Z,1'b1},
        // R10 pair second address wraps
        '{2'd2,1'b1,1'b0,1'b0,1'b0,2'd0,5'd0,2'd0,5'd1,5'd2,5'd3,64'hFFFF_FFFF_FFFF_FFFC,Z,64'hFFFF_FFFF_FFFF_FFFC,Z,1'b1,1'b1,1'b0,Z,1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'd0:    return "R1 R2 R10 vector";
            2'd1:    return "R3 R4 R5 R10 vector";
            2'd2:    return "R6 R7 R10 vector";
            default: return "R8 vector";
        endcase
    endfunction

    task automatic drive(input vec_t v);
        op_cls = v.op; is_load = v.ld; idx_zext = v.zx; pre_inc = v.pre;
        pair_dw = v.dw; scale = v.sc; step_imm = v.imm; pair_imm = v.pimm;
        rs_base = v.rs; rd_a = v.ra; rd_b = v.rb; base = v.b; index = v.ix;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset addr0", addr0, 64'd0);
        chk("R9 reset wb_en", {63'd0, wb_en}, 64'd0);
        chk("R9 reset illegal", {63'd0, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            chk("R9 out_valid", {63'd0, out_valid}, 64'd1);
            chk(tag_of(VECS[i].op), {63'd0, illegal}, {63'd0, VECS[i].e_ill});
            chk(tag_of(VECS[i].op), {63'd0, addr_ok}, {63'd0, VECS[i].e_ok});
            chk(tag_of(VECS[i].op), {63'd0, addr1_en}, {63'd0, VECS[i].e_a1en});
            chk(tag_of(VECS[i].op), {63'd0, wb_en}, {63'd0, VECS[i].e_wb});
            if (VECS[i].e_ok) chk(tag_of(VECS[i].op), addr0, VECS[i].e_a0);
            if (VECS[i].e_a1en) chk(tag_of(VECS[i].op), addr1, VECS[i].e_a1);
            if (VECS[i].e_wb) chk(tag_of(VECS[i].op), wb_data, VECS[i].e_wbd);
        end

        // R9 valid drops one cycle after the strobe drops
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 valid drop", {63'd0, out_valid}, 64'd0);

        // R9 synchronous reset during a strobe clears the outputs
        drive(VECS[4]);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset under strobe valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset under strobe wb_data", wb_data, 64'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R9 watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule